// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block is the configuration register set that a physical function uses to create, size and control its virtual functions. It sits in extended configuration space at a base offset that is a parameter (0x100 or higher, dword aligned). It answers single-dword read and write requests that carry a byte address, four byte enables and 32 bits of data. Read data comes back one cycle after the request. A write takes effect at the clock edge that samples it.

The hardware limits are elaboration constants: the largest VF count, the initial VF count, the routing offset of the first VF, the spacing between VFs, the VF device ID, migration support and the set of supported page sizes. Each of the six VF BARs has a per-VF aperture size that is also a parameter. Software-writable state is checked against cross-field rules before it is stored. The block drives the live control state on ports so that the rest of the function can use it: VF enable, VF memory decode, ARI numbering, the active VF count, the six BAR bases and a flag that marks VF configuration space as ready once a programmable settle time has passed after enable.

Top module: `vf_ctl_regfile`

## Requirements
- R1: A read strobe gives `cfg_rvalid` high on the next cycle, together with the dword at that address. The dword at the base offset reads {next pointer[31:20], version 1h[19:16], ID 0010h[15:0]}. Any address outside the 15-dword window reads zero, and a write to such an address has no effect.
- R2: The following dwords are read-only and do not change when written: base+04h = {migration message number[31:21], zero, migration capable[0]}; base+0Ch = {max VF count[31:16], initial VF count[15:0]}; base+14h = {VF stride[31:16], first VF offset[15:0]}; base+18h = {VF device ID[31:16], zero}; base+1Ch = the supported page-size mask.
- R3: The control dword at base+08h holds VF enable at bit 0, migration enable at bit 1, migration interrupt enable at bit 2, VF memory enable at bit 3 and ARI numbering at bit 4. All other bits read zero. `vf_en_o`, `vf_mse_o` and `ari_o` follow bits 0, 3 and 4. Every output resets to zero.
- R4: Migration enable (bit 1) stays 0 when the migration-capable parameter is 0.
- R5: The VF count is held in base+10h[31:16]. A written value above the maximum VF count is stored as the maximum. `num_vf_o` shows the stored count.
- R6: A write to the VF count while VF enable is 1 leaves the count unchanged.
- R7: The system page size at base+20h resets to 1 (4 KB). A write is accepted only if the merged value has exactly one bit set and that bit is in the supported mask. Otherwise the register keeps its old value.
- R8: The six VF BARs sit at base+24h to base+38h. A BAR with aperture 2^k stores only address bits k and above, so writing all ones reads back ~(2^k-1). A BAR with size parameter 0 reads zero. Each stored value appears on its 32-bit slice of `bar_base_o`, with BAR i at bits [32i+31:32i].
- R9: `vf_ready_o` goes high at the READY_CYCLES-th rising edge after the edge that stores VF enable = 1. It goes low at the same edge that stores VF enable = 0. Writing VF enable = 1 again while VF enable is already 1 does not restart the wait.
- R10: A write changes only the bytes whose enable bit is set (byte i is data bits [8i+7:8i]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write request strobe |
| cfg_rd | input | 1 | Read request strobe |
| cfg_addr | input | ADDR_W | Byte address in extended config space |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| vf_en_o | output | 1 | VF enable |
| vf_mse_o | output | 1 | VF memory decode enable |
| ari_o | output | 1 | ARI function numbering in use |
| num_vf_o | output | 16 | Active VF count |
| bar_base_o | output | 192 | Six VF BAR values, BAR i in bits [32i+31:32i] |
| vf_ready_o | output | 1 | VF configuration space ready |

## Verification
The VF-count lock is the hardest case to reach. A count write can only be rejected while enable is set, so the stimulus first stores a count, then turns enable on and waits out the full ready interval before it tries a new count, and finally clears enable and shows that the same write is now accepted. The ready edge is found by counting edges from the enabling write and sampling on the cycle before and the cycle of the expected rise. The page-size rule is swept over all 32 single-bit values plus zero and a two-bit value. The expected register contents are tracked arithmetically, because a rejected write must leave the previous legal size in place.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;

   localparam int NBAR  = 6;
   localparam int SLOTS = 15;

   localparam logic [15:0] CAP_ID  = 16'h0010;
   localparam logic [3:0]  CAP_VER = 4'h1;

   // dword slots relative to the capability base
   localparam logic [3:0] SL_HDR    = 4'd0;
   localparam logic [3:0] SL_CAPS   = 4'd1;
   localparam logic [3:0] SL_CTRL   = 4'd2;
   localparam logic [3:0] SL_COUNTS = 4'd3;
   localparam logic [3:0] SL_NUMVF  = 4'd4;
   localparam logic [3:0] SL_ROUTE  = 4'd5;
   localparam logic [3:0] SL_DEVID  = 4'd6;
   localparam logic [3:0] SL_PGSUP  = 4'd7;
   localparam logic [3:0] SL_PGSYS  = 4'd8;
   localparam logic [3:0] SL_BAR0   = 4'd9;

   // bit order matches the control dword (vf_en at bit 0)
   typedef struct packed {
      logic ari;
      logic mse;
      logic mig_irq;
      logic mig_en;
      logic vf_en;
   } vf_ctl_t;

   function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [3:0]  be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
      return r;
   endfunction

endpackage

// File: rtl/vfcap_ctrl.sv
module vfcap_ctrl
   import vfcap_pkg::*;
#(
   parameter int TOTAL_VFS = 16,
   parameter bit MIG_CAP   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic          ctl_be,
   input  logic [4:0]    ctl_wbits,
   input  logic          num_we,
   input  logic [1:0]    num_be,
   input  logic [15:0]   num_wdata,
   output vf_ctl_t       ctl_q,
   output vf_ctl_t       ctl_d,
   output logic [15:0]   num_q
);

   localparam logic [15:0] MAX_VF = 16'(TOTAL_VFS);

   logic        mig_allow;
   logic [15:0] num_merged;
   logic [15:0] num_d;

   generate
      if (MIG_CAP) begin : g_mig
         assign mig_allow = 1'b1;
      end else begin : g_nomig
         assign mig_allow = 1'b0;
      end
   endgenerate

   always_comb begin
      ctl_d = ctl_q;
      if (ctl_we && ctl_be) begin
         ctl_d        = vf_ctl_t'(ctl_wbits);
         ctl_d.mig_en = ctl_wbits[1] & mig_allow;
      end
   end

   always_comb begin
      num_merged[7:0]  = num_be[0] ? num_wdata[7:0]  : num_q[7:0];
      num_merged[15:8] = num_be[1] ? num_wdata[15:8] : num_q[15:8];
      num_d = num_q;
      if (num_we && !ctl_q.vf_en)
         num_d = (num_merged > MAX_VF) ? MAX_VF : num_merged;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         num_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         num_q <= num_d;
      end
   end

endmodule

// File: rtl/vfcap_ready.sv
module vfcap_ready #(
   parameter int READY_CYCLES = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_next,
   output logic ready_q
);

   localparam int CW = $clog2(READY_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(READY_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (!en_next) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (!ready_q) begin
         if (cnt_q == LIMIT) ready_q <= 1'b1;
         else                cnt_q   <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/vfcap_pagesz.sv
module vfcap_pagesz
   import vfcap_pkg::*;
#(
   parameter logic [31:0] SUPPORTED = 32'h0000_0553
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] sys_q
);

   logic [31:0] cand;
   logic        single;
   logic        legal;

   always_comb begin
      cand   = be_merge(sys_q, wdata, be);
      single = (cand != '0) && ((cand & (cand - 32'd1)) == '0);
      legal  = single && ((cand & SUPPORTED) != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sys_q <= 32'd1;
      else if (we && legal)  sys_q <= cand;
   end

endmodule

// File: rtl/vfcap_bar.sv
module vfcap_bar
   import vfcap_pkg::*;
#(
   parameter int SZ_LOG2 = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] val_q
);

   localparam logic [31:0] ADDR_MASK =
      (SZ_LOG2 == 0) ? 32'h0 : ~((32'h1 << SZ_LOG2) - 32'h1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (we) val_q <= be_merge(val_q, wdata, be) & ADDR_MASK;
   end

endmodule

// File: rtl/vf_ctl_regfile.sv
module vf_ctl_regfile
   import vfcap_pkg::*;
#(
   parameter int          ADDR_W       = 12,
   parameter int          CAP_BASE     = 'h100,
   parameter int          NEXT_PTR     = 'h000,
   parameter int          TOTAL_VFS    = 16,
   parameter int          INITIAL_VFS  = 0,
   parameter int          FIRST_OFS    = 4,
   parameter int          VF_STRIDE    = 2,
   parameter logic [15:0] VF_DEV_ID    = 16'h1000,
   parameter bit          MIG_CAP      = 1'b0,
   parameter int          MIG_MSG      = 0,
   parameter logic [31:0] SUPPORTED    = 32'h0000_0553,
   parameter logic [47:0] BAR_LOG2     = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd12},
   parameter int          READY_CYCLES = 25_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic                 cfg_rd,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [3:0]           cfg_be,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   output logic                 cfg_rvalid,
   output logic                 vf_en_o,
   output logic                 vf_mse_o,
   output logic                 ari_o,
   output logic [15:0]          num_vf_o,
   output logic [NBAR*32-1:0]   bar_base_o,
   output logic                 vf_ready_o
);

   localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(CAP_BASE);
   localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(SLOTS * 4);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 9 || ADDR_W > 16)
         $error("ADDR_W out of range");
      if (CAP_BASE < 'h100 || (CAP_BASE % 4) != 0)
         $error("CAP_BASE must be dword aligned at 0x100 or above");
      if (TOTAL_VFS < 1 || TOTAL_VFS > 65535)
         $error("TOTAL_VFS out of range");
      if (INITIAL_VFS < 0 || INITIAL_VFS > TOTAL_VFS)
         $error("INITIAL_VFS exceeds TOTAL_VFS");
      if (SUPPORTED[0] != 1'b1)
         $error("4 KB page size must be supported");
      if (READY_CYCLES < 1)
         $error("READY_CYCLES must be at least 1");
      if (MIG_MSG < 0 || MIG_MSG > 2047)
         $error("MIG_MSG must fit 11 bits");
   endgenerate

   logic [ADDR_W-1:0] off;
   logic              in_win;
   logic [3:0]        idx;
   logic              wr_hit;

   assign off    = cfg_addr - BASE_A;
   assign in_win = (cfg_addr >= BASE_A) && (off < WIN_BYTES);
   assign idx    = off[5:2];
   assign wr_hit = cfg_wr && in_win;

   // control and VF count
   vf_ctl_t     ctl_q;
   vf_ctl_t     ctl_d;
   logic [15:0] num_q;

   vfcap_ctrl #(
      .TOTAL_VFS (TOTAL_VFS),
      .MIG_CAP   (MIG_CAP)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (wr_hit && idx == SL_CTRL),
      .ctl_be    (cfg_be[0]),
      .ctl_wbits (cfg_wdata[4:0]),
      .num_we    (wr_hit && idx == SL_NUMVF),
      .num_be    (cfg_be[3:2]),
      .num_wdata (cfg_wdata[31:16]),
      .ctl_q     (ctl_q),
      .ctl_d     (ctl_d),
      .num_q     (num_q)
   );

   vfcap_ready #(
      .READY_CYCLES (READY_CYCLES)
   ) u_ready (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_next (ctl_d.vf_en),
      .ready_q (vf_ready_o)
   );

   // system page size
   logic [31:0] sys_page_q;

   vfcap_pagesz #(
      .SUPPORTED (SUPPORTED)
   ) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_hit && idx == SL_PGSYS),
      .be    (cfg_be),
      .wdata (cfg_wdata),
      .sys_q (sys_page_q)
   );

   // VF BARs
   logic [31:0] bar_val [NBAR];

   generate
      for (genvar i = 0; i < NBAR; i++) begin : g_bar
         localparam int SZ = int'(BAR_LOG2[i*8 +: 8]);
         if (SZ != 0 && (SZ < 4 || SZ > 31))
            $error("BAR size log2 must be 0 or 4..31");
         vfcap_bar #(
            .SZ_LOG2 (SZ)
         ) u_bar (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_hit && idx == 4'(SL_BAR0 + 4'(i))),
            .be    (cfg_be),
            .wdata (cfg_wdata),
            .val_q (bar_val[i])
         );
         assign bar_base_o[i*32 +: 32] = bar_val[i];
      end
   endgenerate

   // read path
   logic [31:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      case (idx)
         SL_HDR:    rd_mux = {12'(NEXT_PTR), CAP_VER, CAP_ID};
         SL_CAPS:   rd_mux = {11'(MIG_MSG), 20'd0, MIG_CAP};
         SL_CTRL:   rd_mux = {27'd0, ctl_q};
         SL_COUNTS: rd_mux = {16'(TOTAL_VFS), 16'(INITIAL_VFS)};
         SL_NUMVF:  rd_mux = {num_q, 16'd0};
         SL_ROUTE:  rd_mux = {16'(VF_STRIDE), 16'(FIRST_OFS)};
         SL_DEVID:  rd_mux = {VF_DEV_ID, 16'd0};
         SL_PGSUP:  rd_mux = SUPPORTED;
         SL_PGSYS:  rd_mux = sys_page_q;
         default: begin
            for (int i = 0; i < NBAR; i++)
               if (idx == 4'(SL_BAR0 + 4'(i))) rd_mux = bar_val[i];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rdata  <= '0;
         cfg_rvalid <= 1'b0;
      end else begin
         cfg_rvalid <= cfg_rd;
         if (cfg_rd) cfg_rdata <= in_win ? rd_mux : 32'd0;
      end
   end

   assign vf_en_o  = ctl_q.vf_en;
   assign vf_mse_o = ctl_q.mse;
   assign ari_o    = ctl_q.ari;
   assign num_vf_o = num_q;

endmodule

// File: rtl/vfcap_chk.sv
module vfcap_chk #(
   parameter int          TOTAL_VFS    = 16,
   parameter int          READY_CYCLES = 25_000_000,
   parameter logic [31:0] SUPPORTED    = 32'h0000_0553,
   parameter bit          MIG_CAP      = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_rd,
   input logic        cfg_rvalid,
   input logic        vf_en_o,
   input logic        vf_ready_o,
   input logic [15:0] num_vf_o,
   input logic [31:0] sys_page,
   input logic        mig_en
);

   localparam int CW = $clog2(READY_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(READY_CYCLES);

   // edges seen with VF enable high, saturating at the ready limit
   logic [CW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            wait_q <= '0;
      else if (!vf_en_o)     wait_q <= '0;
      else if (wait_q < LIMIT) wait_q <= wait_q + 1'b1;
   end

   AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd |=> cfg_rvalid);                                          // R1
   AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> !cfg_rvalid);                                        // R1
   AST_NUMVF_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      num_vf_o <= 16'(TOTAL_VFS));                                     // R5
   AST_NUMVF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(vf_en_o) |-> $stable(num_vf_o));                           // R6
   AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sys_page) && ((sys_page & SUPPORTED) != '0));            // R7
   AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      vf_ready_o |-> vf_en_o);                                         // R9
   AST_READY_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      vf_ready_o |-> (wait_q >= LIMIT));                               // R9

   generate
      if (!MIG_CAP) begin : g_nomig
         AST_MIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            vf_en_o |-> !mig_en);                                      // R4
         AST_MIG_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !vf_en_o |-> !mig_en);                                     // R4
      end
   endgenerate

endmodule

bind vf_ctl_regfile vfcap_chk #(
   .TOTAL_VFS    (TOTAL_VFS),
   .READY_CYCLES (READY_CYCLES),
   .SUPPORTED    (SUPPORTED),
   .MIG_CAP      (MIG_CAP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_rd     (cfg_rd),
   .cfg_rvalid (cfg_rvalid),
   .vf_en_o    (vf_en_o),
   .vf_ready_o (vf_ready_o),
   .num_vf_o   (num_vf_o),
   .sys_page   (sys_page_q),
   .mig_en     (ctl_q.mig_en)
);

// File: tb/test_vf_ctl_regfile.sv
module test_vf_ctl_regfile;

   localparam int          AW    = 12;
   localparam int          BASE  = 'h180;
   localparam int          TOT   = 16;
   localparam int          RDY   = 20;
   localparam logic [31:0] SUPP  = 32'h0000_0553;
   localparam logic [47:0] BARS  = {8'd0, 8'd13, 8'd16, 8'd0, 8'd14, 8'd12};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic          cfg_rd = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [3:0]    cfg_be = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          cfg_rvalid;
   logic          vf_en_o, vf_mse_o, ari_o, vf_ready_o;
   logic [15:0]   num_vf_o;
   logic [191:0]  bar_base_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vf_ctl_regfile #(
      .ADDR_W (AW), .CAP_BASE (BASE), .NEXT_PTR (0), .TOTAL_VFS (TOT),
      .INITIAL_VFS (4), .FIRST_OFS (4), .VF_STRIDE (2), .VF_DEV_ID (16'h1A2B),
      .MIG_CAP (1'b0), .MIG_MSG (5), .SUPPORTED (SUPP), .BAR_LOG2 (BARS),
      .READY_CYCLES (RDY)
   ) i_vf_ctl_regfile (
      .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_rd (cfg_rd),
      .cfg_addr (cfg_addr), .cfg_be (cfg_be), .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata), .cfg_rvalid (cfg_rvalid), .vf_en_o (vf_en_o),
      .vf_mse_o (vf_mse_o), .ari_o (ari_o), .num_vf_o (num_vf_o),
      .bar_base_o (bar_base_o), .vf_ready_o (vf_ready_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int ofs, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = AW'(BASE + ofs); cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input int abs_addr, output logic [31:0] d, output logic v);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_addr = AW'(abs_addr);
      @(negedge clk);
      cfg_rd = 1'b0;
      d = cfg_rdata; v = cfg_rvalid;
   endtask

   function automatic logic [31:0] bar_mask(input int i);
      int sz = int'(BARS[i*8 +: 8]);
      return (sz == 0) ? 32'h0 : ~((32'h1 << sz) - 32'h1);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        v;
      logic [31:0] exp_pg;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R3: reset state of all outputs
      check("R3 reset en/mse/ari/ready", {28'd0, vf_en_o, vf_mse_o, ari_o, vf_ready_o}, 32'd0);
      check("R3 reset num_vf", {16'd0, num_vf_o}, 32'd0);
      check("R8 reset bar bases", {31'd0, |bar_base_o}, 32'd0);

      // R1: header, valid timing, window edges
      rd(BASE, d, v);
      check("R1 header", d, 32'h0001_0010);
      check("R1 rvalid", {31'd0, v}, 32'd1);
      rd(BASE - 4, d, v);
      check("R1 below window", d, 32'd0);
      rd(BASE + 'h3C, d, v);
      check("R1 above window", d, 32'd0);
      wr('h3C, 32'hFFFF_FFFF, 4'hF);
      rd(BASE + 'h3C, d, v);
      check("R1 write outside window", d, 32'd0);

      // R2: read-only constants, before and after an all-ones write
      for (int pass = 0; pass < 2; pass++) begin
         if (pass == 1) begin
            wr('h00, 32'hFFFF_FFFF, 4'hF); wr('h04, 32'hFFFF_FFFF, 4'hF);
            wr('h0C, 32'hFFFF_FFFF, 4'hF); wr('h14, 32'hFFFF_FFFF, 4'hF);
            wr('h18, 32'hFFFF_FFFF, 4'hF); wr('h1C, 32'hFFFF_FFFF, 4'hF);
         end
         rd(BASE + 'h00, d, v); check("R2 header const", d, 32'h0001_0010);
         rd(BASE + 'h04, d, v); check("R2 capabilities", d, 32'h00A0_0000);
         rd(BASE + 'h0C, d, v); check("R2 vf counts", d, 32'h0010_0004);
         rd(BASE + 'h14, d, v); check("R2 offset/stride", d, 32'h0002_0004);
         rd(BASE + 'h18, d, v); check("R2 device id", d, 32'h1A2B_0000);
         rd(BASE + 'h1C, d, v); check("R2 page mask", d, SUPP);
      end

      // R3 / R4: control bits, migration enable dropped
      wr('h08, 32'h0000_001E, 4'hF);
      rd(BASE + 'h08, d, v);
      check("R4 mig bit cleared, R3 ctrl", d, 32'h0000_001C);
      check("R3 outputs en/mse/ari", {29'd0, vf_en_o, vf_mse_o, ari_o}, 32'b011);

      // R5 sweep with enable low
      for (int n = 0; n <= 40; n++) begin
         wr('h10, {16'(n), 16'h0000}, 4'hF);
         check("R5 num clamp port", {16'd0, num_vf_o}, (n > TOT) ? TOT : n);
      end
      wr('h10, 32'hFFFF_0000, 4'hF);
      rd(BASE + 'h10, d, v);
      check("R5 num clamp readback", d, {16'(TOT), 16'h0});

      // R10: partial byte writes
      wr('h10, 32'h0000_0000, 4'hF);
      wr('h10, 32'h0305_0000, 4'b0100);
      check("R10 num low byte only", {16'd0, num_vf_o}, 32'd5);
      wr('h10, 32'h0000_0000, 4'b1000);
      check("R10 num high byte zero", {16'd0, num_vf_o}, 32'd5);

      // R9: ready timing after enable
      wr('h10, {16'd7, 16'h0}, 4'hF);
      wr('h08, 32'h0000_001F, 4'hF);
      check("R3 vf_en set", {31'd0, vf_en_o}, 32'd1);
      repeat (RDY - 1) @(posedge clk);
      @(negedge clk);
      check("R9 not ready one edge early", {31'd0, vf_ready_o}, 32'd0);
      @(posedge clk); @(negedge clk);
      check("R9 ready on time", {31'd0, vf_ready_o}, 32'd1);
      wr('h08, 32'h0000_0019, 4'hF);
      check("R9 re-enable keeps ready", {31'd0, vf_ready_o}, 32'd1);

      // R6: count locked while enabled
      wr('h10, {16'd3, 16'h0}, 4'hF);
      check("R6 num locked", {16'd0, num_vf_o}, 32'd7);
      wr('h08, 32'h0000_0000, 4'hF);
      check("R9 ready drops with enable", {30'd0, vf_en_o, vf_ready_o}, 32'd0);
      wr('h10, {16'd3, 16'h0}, 4'hF);
      check("R6 num unlocked", {16'd0, num_vf_o}, 32'd3);

      // R7: page size sweep
      exp_pg = 32'd1;
      rd(BASE + 'h20, d, v);
      check("R7 page reset", d, exp_pg);
      for (int b = 0; b < 32; b++) begin
         wr('h20, 32'h1 << b, 4'hF);
         if (SUPP[b]) exp_pg = 32'h1 << b;
         rd(BASE + 'h20, d, v);
         check("R7 page single bit", d, exp_pg);
      end
      wr('h20, 32'h0, 4'hF);
      rd(BASE + 'h20, d, v); check("R7 page zero rejected", d, exp_pg);
      wr('h20, 32'h3, 4'hF);
      rd(BASE + 'h20, d, v); check("R7 page two bits rejected", d, exp_pg);

      // R8: BAR sizing and base
      for (int i = 0; i < 6; i++) begin
         wr('h24 + 4*i, 32'hFFFF_FFFF, 4'hF);
         rd(BASE + 'h24 + 4*i, d, v);
         check("R8 bar sizing", d, bar_mask(i));
         wr('h24 + 4*i, 32'h9E5A_3C71, 4'hF);
         rd(BASE + 'h24 + 4*i, d, v);
         check("R8 bar base", d, 32'h9E5A_3C71 & bar_mask(i));
         check("R8 bar port", bar_base_o[i*32 +: 32], 32'h9E5A_3C71 & bar_mask(i));
         wr('h24 + 4*i, 32'h0, 4'hF);
         wr('h24 + 4*i, 32'hAABB_CCDD, 4'b1000);
         check("R10 bar byte 3 only", bar_base_o[i*32 +: 32], 32'hAA00_0000 & bar_mask(i));
      end

      // R3 / R4: all ones into control
      wr('h08, 32'hFFFF_FFFF, 4'hF);
      rd(BASE + 'h08, d, v);
      check("R4 all-ones ctrl", d, 32'h0000_001D);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule